// File: doc/BRIEF.md
# Indirect Register Access Port

This block sits between a host bus and the register file of a peripheral controller. The host writes an 8-bit index into a single pointer register. It then reaches one of two register banks through a data port for each bank: a control/status bank and a bus-configuration bank. The same pointer value indexes both banks. Which bank is reached depends only on the data port the host touches.

The I/O offsets of the pointer port and the bus-configuration data port change with the I/O width. After hard reset the block is in word mode. The first 32-bit write to the control/status data port switches it to doubleword mode, and it stays there until the next hard reset. A separate configuration-space path serves four header bytes: an interrupt routing byte the host may use freely, a fixed interrupt-pin code, and two read-only bytes that mirror the low and high halves of bus-configuration register 22.

Reset comes in two forms. Hard reset restores everything. Soft reset restores the control/status bank only and keeps the configuration bank, the pointer, the width mode and the interrupt routing byte. Each read returns its data one clock after the request.

Top module: `rap_port_top`

## Requirements
- R1: The pointer port is at I/O offset 12h in word mode and 14h in doubleword mode. A write stores acc_wdata[7:0]. A read returns the pointer in bits 7:0 and zero in bits 31:8. The pointer is 0 after hard reset.
- R2: The control/status data port is at offset 10h in both modes. A write stores acc_wdata[15:0] into control/status register [pointer], and a read returns that register zero-extended.
- R3: The bus-configuration data port is at offset 16h in word mode and 1Ch in doubleword mode. It reads and writes bus-configuration register [pointer]. All bus-configuration registers except register 22 are 0 after hard reset.
- R4: Word mode holds after hard reset. A write with acc_dw=1 to offset 10h selects doubleword mode, and that write also lands in the register. The mode then stays set until hard reset. A 32-bit write to any other offset leaves the mode unchanged. In each mode the other mode's pointer and bus-configuration offsets are unmapped.
- R5: A data-port access with a pointer value of 32 or more (the bank depth) is ignored on write and reads 0. There is no wrap onto a lower register.
- R6: Configuration byte 3Eh reads bits 7:0 of bus-configuration register 22, and byte 3Fh reads bits 15:8. Writes to either byte are ignored. Register 22 resets to 1806h on hard reset.
- R7: Configuration byte 3Ch is host read/write. Hard reset clears it, and soft reset leaves it unchanged.
- R8: Configuration byte 3Dh always reads 01h, and writes to it are ignored.
- R9: Soft reset returns the control/status bank to its defaults: register 0 is 0004h and all others are 0. It keeps the bus-configuration bank, the pointer and the width mode.
- R10: rd_valid is high exactly one cycle after a read request, with rd_data valid in that cycle. Configuration reads return their byte in bits 7:0. Unmapped offsets read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| acc_valid | input | 1 | Access request, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_cfg | input | 1 | 1 = configuration space, 0 = I/O space |
| acc_dw | input | 1 | 1 = 32-bit access |
| acc_addr | input | 8 | Byte offset within the selected space |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
The assertions assume that each access is a single-cycle request whose address and write data are stable in that cycle. They also assume that soft reset is a short pulse outside hard reset, and that after release the inputs are driven to known values. The stimulus follows these rules: each access lasts exactly one cycle, and the bench applies every input change at the falling edge, away from the capturing edge. The bench follows a fixed programme. It first writes a value to a register and then reads it back, so the expected value follows directly from the requirements. It crosses a width-mode switch, a soft reset and a second hard reset, checking after each of them both the state that must survive and the state that must be restored.

// File: rtl/rap_pkg.sv
// Package: shared offsets, port selection type and reset values for the
// indirect register access port. Assumes 8-bit I/O and configuration offsets.
package rap_pkg;

    // I/O offsets; positions are fixed by the host software model
    localparam logic [7:0] OFF_CSR_DATA   = 8'h10;
    localparam logic [7:0] OFF_PTR_WORD   = 8'h12;
    localparam logic [7:0] OFF_PTR_DWORD  = 8'h14;
    localparam logic [7:0] OFF_BCR_WORD   = 8'h16;
    localparam logic [7:0] OFF_BCR_DWORD  = 8'h1C;

    // Configuration header bytes
    localparam logic [7:0] CFG_IRQ_ROUTE  = 8'h3C;
    localparam logic [7:0] CFG_IRQ_PIN    = 8'h3D;
    localparam logic [7:0] CFG_BURST_LO   = 8'h3E;
    localparam logic [7:0] CFG_BURST_HI   = 8'h3F;
    localparam logic [7:0] IRQ_PIN_CODE   = 8'h01;

    // Bus-configuration register mirrored into the header
    localparam int MIRROR_IDX = 22;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PTR  = 2'd1,
        SEL_CSR  = 2'd2,
        SEL_BCR  = 2'd3
    } port_sel_e;

    // Default of a control/status register
    function automatic logic [15:0] csr_reset_val(input int idx);
        return (idx == 0) ? 16'h0004 : 16'h0000;
    endfunction

    // Default of a bus-configuration register
    function automatic logic [15:0] bcr_reset_val(input int idx);
        return (idx == MIRROR_IDX) ? 16'h1806 : 16'h0000;
    endfunction

endpackage

// File: rtl/rap_io_decode.sv
// Module: I/O offset decoder. Maps an I/O offset to the port it addresses,
// taking the current width mode into account. Pure combinational logic;
// assumes the caller qualifies the result with a valid I/O access.
module rap_io_decode
    import rap_pkg::*;
(
    input  logic [7:0] addr,
    input  logic       dw_mode,
    output port_sel_e  sel
);

    logic [7:0] ptr_off;
    logic [7:0] bcr_off;

    // Width-dependent offsets of the pointer and bus-configuration ports
    always_comb begin
        ptr_off = dw_mode ? OFF_PTR_DWORD : OFF_PTR_WORD;
        bcr_off = dw_mode ? OFF_BCR_DWORD : OFF_BCR_WORD;
    end

    // Select the addressed port; anything else is unmapped
    always_comb begin
        if (addr == OFF_CSR_DATA)
            sel = SEL_CSR;
        else if (addr == ptr_off)
            sel = SEL_PTR;
        else if (addr == bcr_off)
            sel = SEL_BCR;
        else
            sel = SEL_NONE;
    end

endmodule

// File: rtl/rap_regbank.sv
// Module: generic register bank of DEPTH words. Writes land only when the
// index is below DEPTH; reads outside the range return zero. One word is
// also exposed as a fixed tap. Assumes 2 <= DEPTH <= 256, WIDTH <= 16 and
// ALIAS_IDX < DEPTH. Soft clear restores the defaults when enabled.
module rap_regbank
    import rap_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int WIDTH     = 16,
    parameter bit IS_CSR    = 1'b1,
    parameter int ALIAS_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             wr_en,
    input  logic [7:0]       idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rd_word,
    output logic [WIDTH-1:0] alias_word
);

    localparam int         IW      = $clog2(DEPTH);
    localparam logic [8:0] DEPTH_L = 9'(DEPTH);

    logic [DEPTH-1:0][WIDTH-1:0] mem;
    logic                        in_range;
    logic [IW-1:0]               slot;

    // Range check and slot index from the shared pointer
    always_comb begin
        in_range = ({1'b0, idx} < DEPTH_L);
        slot     = idx[IW-1:0];
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam logic [15:0] INIT16 = IS_CSR ? csr_reset_val(i) : bcr_reset_val(i);
        localparam logic [WIDTH-1:0] INIT = INIT16[WIDTH-1:0];

        // Hold one word: reset or clear to default, else take a matching write
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr)
                mem[i] <= INIT;
            else if (wr_en && in_range && (slot == IW'(i)))
                mem[i] <= wdata;
        end
    end

    // Read the addressed word, zero when out of range
    always_comb begin
        rd_word    = in_range ? mem[slot] : '0;
        alias_word = mem[ALIAS_IDX];
    end

    // R5
    oob_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_range && !soft_clr) |=> $stable(mem));

endmodule

// File: rtl/rap_cfg_header.sv
// Module: configuration header bytes. Holds the interrupt routing byte
// (host read/write, hard reset only) and serves the fixed pin code and the
// two read-only mirror bytes of a bus-configuration word. Byte-wide access.
module rap_cfg_header
    import rap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    input  logic [15:0] mirror_word,
    output logic [7:0]  rd_byte
);

    logic [7:0] irq_route;

    // Interrupt routing byte; cleared by hard reset only
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_route <= 8'h00;
        else if (wr_en && (addr == CFG_IRQ_ROUTE))
            irq_route <= wdata;
    end

    // Header read mux
    always_comb begin
        case (addr)
            CFG_IRQ_ROUTE: rd_byte = irq_route;
            CFG_IRQ_PIN:   rd_byte = IRQ_PIN_CODE;
            CFG_BURST_LO:  rd_byte = mirror_word[7:0];
            CFG_BURST_HI:  rd_byte = mirror_word[15:8];
            default:       rd_byte = 8'h00;
        endcase
    end

    // R7
    irq_route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == CFG_IRQ_ROUTE)) |=> $stable(irq_route));

endmodule

// File: rtl/rap_port_top.sv
// Module: indirect register access port top. Holds the shared pointer and
// the width mode, routes I/O accesses to the two banks, serves the
// configuration header and registers read data one cycle after a request.
// Assumes single-cycle access requests.
module rap_port_top
    import rap_pkg::*;
#(
    parameter int CSR_DEPTH = 32,
    parameter int BCR_DEPTH = 32,
    parameter int REG_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic        acc_cfg,
    input  logic        acc_dw,
    input  logic [7:0]  acc_addr,
    input  logic [31:0] acc_wdata,
    output logic        rd_valid,
    output logic [31:0] rd_data
);

    localparam int PAD_W = 32 - REG_W;

    port_sel_e        sel;
    logic             dw_mode;
    logic [7:0]       ptr;
    logic             io_wr;
    logic             cfg_wr;
    logic             rd_req;
    logic [REG_W-1:0] csr_rd;
    logic [REG_W-1:0] bcr_rd;
    logic [REG_W-1:0] csr0_word;
    logic [REG_W-1:0] mirror_word;
    logic [7:0]       cfg_byte;
    logic [31:0]      rd_mux;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^acc_wdata[31:REG_W];

    // Qualify the request by space and direction
    always_comb begin
        io_wr  = acc_valid && acc_write && !acc_cfg;
        cfg_wr = acc_valid && acc_write && acc_cfg;
        rd_req = acc_valid && !acc_write;
    end

    rap_io_decode u_decode (
        .addr    (acc_addr),
        .dw_mode (dw_mode),
        .sel     (sel)
    );

    // Shared pointer; only hard reset clears it
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= 8'h00;
        else if (io_wr && (sel == SEL_PTR))
            ptr <= acc_wdata[7:0];
    end

    // Sticky width mode set by a 32-bit control/status data write
    always_ff @(posedge clk) begin
        if (!rst_n)
            dw_mode <= 1'b0;
        else if (io_wr && (sel == SEL_CSR) && acc_dw)
            dw_mode <= 1'b1;
    end

    rap_regbank #(
        .DEPTH     (CSR_DEPTH),
        .WIDTH     (REG_W),
        .IS_CSR    (1'b1),
        .ALIAS_IDX (0)
    ) u_csr_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (soft_rst),
        .wr_en      (io_wr && (sel == SEL_CSR)),
        .idx        (ptr),
        .wdata      (acc_wdata[REG_W-1:0]),
        .rd_word    (csr_rd),
        .alias_word (csr0_word)
    );

    rap_regbank #(
        .DEPTH     (BCR_DEPTH),
        .WIDTH     (REG_W),
        .IS_CSR    (1'b0),
        .ALIAS_IDX (MIRROR_IDX)
    ) u_bcr_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (1'b0),
        .wr_en      (io_wr && (sel == SEL_BCR)),
        .idx        (ptr),
        .wdata      (acc_wdata[REG_W-1:0]),
        .rd_word    (bcr_rd),
        .alias_word (mirror_word)
    );

    rap_cfg_header u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr),
        .addr        (acc_addr),
        .wdata       (acc_wdata[7:0]),
        .mirror_word (mirror_word),
        .rd_byte     (cfg_byte)
    );

    // Read data selection across both spaces
    always_comb begin
        if (acc_cfg) begin
            rd_mux = {24'h0, cfg_byte};
        end else begin
            case (sel)
                SEL_PTR: rd_mux = {24'h0, ptr};
                SEL_CSR: rd_mux = {{PAD_W{1'b0}}, csr_rd};
                SEL_BCR: rd_mux = {{PAD_W{1'b0}}, bcr_rd};
                default: rd_mux = 32'h0;
            endcase
        end
    end

    // Register the read response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 32'h0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req)
                rd_data <= rd_mux;
        end
    end

    // R1
    ptr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_req && !acc_cfg && (sel == SEL_PTR)))
            |-> (rd_data == {24'h0, $past(ptr)}));

    // R4
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dw_mode |=> dw_mode);

    // R4
    mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (acc_addr == OFF_CSR_DATA) && acc_dw) |=> dw_mode);

    // R6
    mirror_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_req && acc_cfg && (acc_addr == CFG_BURST_LO)))
            |-> (rd_data == {24'h0, $past(mirror_word[7:0])}));

    // R8
    irq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_req && acc_cfg && (acc_addr == CFG_IRQ_PIN)))
            |-> (rd_data == 32'h1));

    // R9
    ptr_soft_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !(io_wr && (sel == SEL_PTR))) |=> $stable(ptr));

    // R9
    csr0_soft_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (csr0_word == csr_reset_val(0)));

    // R10
    rd_valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

endmodule

// File: tb/tb_rap_port_top.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor at the
// falling edge pops and compares each response.
module tb_rap_port_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_cfg = 1'b0;
    logic        acc_dw = 1'b0;
    logic [7:0]  acc_addr = 8'h0;
    logic [31:0] acc_wdata = 32'h0;
    logic        rd_valid;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    rap_port_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_cfg   (acc_cfg),
        .acc_dw    (acc_dw),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // Write access, called at a falling edge
    task automatic wr(input logic cfg, input logic [7:0] addr, input logic dw,
                      input logic [31:0] data);
        acc_valid = 1'b1; acc_write = 1'b1; acc_cfg = cfg;
        acc_dw = dw; acc_addr = addr; acc_wdata = data;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    // Read access, pushes expected value for the monitor
    task automatic rd(input logic cfg, input logic [7:0] addr,
                      input logic [31:0] exp, input string tag);
        acc_valid = 1'b1; acc_write = 1'b0; acc_cfg = cfg;
        acc_dw = 1'b0; acc_addr = addr; acc_wdata = 32'h0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Monitor: compare every response against the scoreboard
    always @(negedge clk) begin
        if (rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected response actual=%h expected=none", rd_data);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state, word mode
        rd(0, 8'h12, 32'h0,      "R1 pointer after reset");
        rd(0, 8'h10, 32'h0004,   "R9 CSR0 default");
        rd(1, 8'h3E, 32'h06,     "R6 mirror low default");
        rd(1, 8'h3F, 32'h18,     "R6 mirror high default");
        rd(1, 8'h3D, 32'h01,     "R8 pin code");
        rd(1, 8'h3C, 32'h00,     "R7 routing after reset");

        // Pointer with reserved bits set; 32-bit write elsewhere keeps mode
        wr(0, 8'h12, 1, 32'hFFFF_0005);
        rd(0, 8'h12, 32'h05,     "R1 reserved bits read zero");
        rd(0, 8'h14, 32'h0,      "R4 dword pointer offset unmapped in word mode");

        // Both banks through the shared pointer
        wr(0, 8'h10, 0, 32'h0000_ABCD);
        rd(0, 8'h10, 32'hABCD,   "R2 CSR5 readback");
        wr(0, 8'h16, 0, 32'h0000_1234);
        rd(0, 8'h16, 32'h1234,   "R3 BCR5 readback");
        rd(0, 8'h10, 32'hABCD,   "R2 CSR5 separate from BCR5");
        rd(0, 8'h1C, 32'h0,      "R10 unmapped 1Ch in word mode");
        wr(0, 8'h20, 0, 32'h0000_5555);
        rd(0, 8'h20, 32'h0,      "R10 unmapped offset");

        // Mirror of BCR22
        wr(0, 8'h12, 0, 32'h16);
        wr(0, 8'h16, 0, 32'h2A3B);
        rd(1, 8'h3E, 32'h3B,     "R6 mirror low");
        rd(1, 8'h3F, 32'h2A,     "R6 mirror high");
        wr(1, 8'h3E, 0, 32'hFF);
        wr(1, 8'h3F, 0, 32'hEE);
        rd(1, 8'h3E, 32'h3B,     "R6 mirror low write ignored");
        rd(0, 8'h16, 32'h2A3B,   "R6 BCR22 unchanged by header write");

        // Header bytes
        wr(1, 8'h3D, 0, 32'h07);
        rd(1, 8'h3D, 32'h01,     "R8 pin write ignored");
        wr(1, 8'h3C, 0, 32'h5A);
        rd(1, 8'h3C, 32'h5A,     "R7 routing readback");

        // Out-of-range pointer
        wr(0, 8'h12, 0, 32'h28);
        wr(0, 8'h10, 0, 32'h1111);
        rd(0, 8'h10, 32'h0,      "R5 CSR out of range");
        wr(0, 8'h16, 0, 32'h2222);
        rd(0, 8'h16, 32'h0,      "R5 BCR out of range");
        wr(0, 8'h12, 0, 32'h08);
        rd(0, 8'h10, 32'h0,      "R5 no wrap into CSR8");
        rd(0, 8'h16, 32'h0,      "R5 no wrap into BCR8");

        // Switch to doubleword mode
        wr(0, 8'h12, 0, 32'h03);
        wr(0, 8'h10, 1, 32'h0000_7777);
        rd(0, 8'h14, 32'h03,     "R4 pointer moved to 14h");
        rd(0, 8'h12, 32'h0,      "R4 12h unmapped in dword mode");
        rd(0, 8'h10, 32'h7777,   "R4 mode-setting write landed");
        wr(0, 8'h14, 0, 32'h05);
        rd(0, 8'h1C, 32'h1234,   "R3 BCR5 via 1Ch");
        rd(0, 8'h16, 32'h0,      "R4 16h unmapped in dword mode");
        wr(0, 8'h1C, 0, 32'h4444);
        rd(0, 8'h1C, 32'h4444,   "R3 BCR5 write via 1Ch");
        wr(0, 8'h10, 0, 32'h0000_0101);
        rd(0, 8'h14, 32'h05,     "R4 mode stays after 16-bit write");

        // Soft reset
        wr(0, 8'h14, 0, 32'h03);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        rd(0, 8'h14, 32'h03,     "R9 pointer kept, mode kept");
        rd(0, 8'h10, 32'h0,      "R9 CSR3 restored");
        wr(0, 8'h14, 0, 32'h05);
        rd(0, 8'h10, 32'h0,      "R9 CSR5 restored");
        rd(0, 8'h1C, 32'h4444,   "R9 BCR5 kept");
        wr(0, 8'h14, 0, 32'h00);
        rd(0, 8'h10, 32'h0004,   "R9 CSR0 default after soft reset");
        rd(1, 8'h3C, 32'h5A,     "R7 routing kept by soft reset");
        rd(1, 8'h3F, 32'h2A,     "R9 BCR22 kept by soft reset");

        // Hard reset
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(1, 8'h3C, 32'h00,     "R7 routing cleared by hard reset");
        rd(0, 8'h12, 32'h00,     "R4 word mode after hard reset");
        rd(1, 8'h3E, 32'h06,     "R6 mirror low after hard reset");
        wr(0, 8'h12, 0, 32'h05);
        rd(0, 8'h16, 32'h0,      "R3 BCR5 cleared by hard reset");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R10 missing responses actual=%0d expected=0", exp_q.size());
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule